// File: doc/BRIEF.md
# Missed-Tick Task Watchdog with Prioritised Interrupt Encoder

This block sits between a group of interrupt sources and a small CPU. It captures the rising edge of each request line into a pending bit and merges all pending bits onto one active-low, level-sensitive IRQ output. A status value gives the CPU the highest-priority pending source as a small encoded number. Source 0 is the system timer and always wins. The CPU acknowledges a source by writing its encoded number back, which clears only that pending bit.

A watchdog guards against a task that masks interrupts and never gives the processor back. Every timer edge that the encoder forwards advances a miss counter. The counter is cleared whenever the CPU writes a task-mapping (segment) register. Such a write only happens when the operating system switches tasks, so it serves as proof that the scheduler ran. When the count reaches a programmable limit, the block drives a single low pulse on its NMI output so that the operating system can take back control. After that the watchdog stays quiet until the next task switch.

Top module: `missed_tick_watchdog`

## Requirements
- R1: After reset, `irqN` and `nmiN` are high and `statusIdx` is 0. The watchdog limit holds the nonzero value `LIMIT_DEF` (default 5), so with no task switch the `LIMIT_DEF`-th timer edge raises NMI.
- R2: A rising edge on `reqIn[i]` sets that source's pending bit at the capturing clock edge. A level that stays high does not set the bit again after it has been acknowledged.
- R3: `statusIdx` equals i+1 for the lowest-numbered pending source i, and 0 when nothing is pending. Source 0 (the timer) therefore reads as 1 and has the top priority.
- R4: A lower-priority pending request is kept while a higher one is shown. Acknowledging the higher one exposes the lower one.
- R5: A write with `ackWr` high clears only the source whose encoded number (i+1) is on `ackIdx`. A new rising edge on the same source in the same cycle wins, and the bit stays set.
- R6: Each rising edge on `reqIn[0]` advances the miss counter by one while the watchdog is armed.
- R7: The timer edge that brings the count to the limit drives `nmiN` low from the next cycle for exactly `NMI_LEN` cycles. After that `nmiN` goes high again.
- R8: After an NMI the counter stops and no further NMI is raised until a segment write re-arms the watchdog.
- R9: `segWr` clears the count and re-arms the watchdog. A timer edge in the same cycle as `segWr` is not counted.
- R10: `limitWr` loads `limitData` as the new limit. A limit of 0 turns the watchdog off.
- R11: `irqN` is low exactly when at least one source is pending, that is, when `statusIdx` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Raw request lines, bit 0 is the timer |
| ackWr | input | 1 | Acknowledge strobe |
| ackIdx | input | IDX_W | Encoded source (i+1) to clear |
| segWr | input | 1 | Strobe for a segment (task mapping) register write |
| limitWr | input | 1 | Load strobe for the watchdog limit |
| limitData | input | CNT_W | New limit value |
| statusIdx | output | IDX_W | Highest-priority pending source, 0 when none |
| irqN | output | 1 | Active-low level interrupt to the CPU |
| nmiN | output | 1 | Active-low non-maskable pulse |

## Verification
The pulse-width and no-refire properties assume that the watchdog is never re-armed and driven to its limit again while an NMI pulse is still low. A second firing inside the pulse would only stretch it. The bench therefore lets each pulse finish, with `NMI_LEN`+1 idle cycles, before the next `segWr`. Timer edges are spaced at least two cycles apart, and every stimulus change is made at the falling clock edge.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

  // Strobes issued by the control to the datapath in a single cycle
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic nmiFire;
    logic limitLoad;
  } mtwStrobe_t;

endpackage

// File: rtl/mtw_prio_enc.sv
module mtw_prio_enc #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic [IDX_W-1:0]   idx
);

  // Lowest bit number wins; encoded as bit number plus one
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) idx = IDX_W'(i + 1);
    end
  end

endmodule

// File: rtl/mtw_datapath.sv
module mtw_datapath
  import mtw_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int CNT_W     = 8,
  parameter int NMI_LEN   = 4,
  parameter int LIMIT_DEF = 5,
  parameter int IDX_W     = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               ackWr,
  input  logic [IDX_W-1:0]   ackIdx,
  input  logic [CNT_W-1:0]   limitData,
  input  mtwStrobe_t         strb,
  output logic [NUM_SRC-1:0] pending,
  output logic               timerEdge,
  output logic [CNT_W-1:0]   missCnt,
  output logic [CNT_W-1:0]   limitVal,
  output logic               nmiN
);

  localparam int NMI_W = $clog2(NMI_LEN + 1);

  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] reqRise;
  logic [NUM_SRC-1:0] ackHit;
  logic [NMI_W-1:0]   nmiLeft;

  assign reqRise   = reqIn & ~reqPrev;
  assign timerEdge = reqRise[0];

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      assign ackHit[g] = ackWr && (ackIdx == IDX_W'(g + 1));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          reqPrev[g] <= 1'b0;
          pending[g] <= 1'b0;
        end else begin
          reqPrev[g] <= reqIn[g];
          // a fresh edge outranks an acknowledge in the same cycle
          if (reqRise[g])     pending[g] <= 1'b1;
          else if (ackHit[g]) pending[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missCnt <= '0;
    end else if (strb.cntClr) begin
      missCnt <= '0;
    end else if (strb.cntInc) begin
      missCnt <= missCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitVal <= CNT_W'(LIMIT_DEF);
    end else if (strb.limitLoad) begin
      limitVal <= limitData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiLeft <= '0;
    end else if (strb.nmiFire) begin
      nmiLeft <= NMI_W'(NMI_LEN);
    end else if (nmiLeft != '0) begin
      nmiLeft <= nmiLeft - 1'b1;
    end
  end

  assign nmiN = (nmiLeft == '0);

endmodule

// File: rtl/mtw_control.sv
module mtw_control
  import mtw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timerEdge,
  input  logic             segWr,
  input  logic             limitWr,
  input  logic [CNT_W-1:0] missCnt,
  input  logic [CNT_W-1:0] limitVal,
  output mtwStrobe_t       strb
);

  logic armed;
  logic reachLimit;
  logic cntFull;

  assign cntFull    = (missCnt == {CNT_W{1'b1}});
  assign reachLimit = (limitVal != '0) &&
                      (({1'b0, missCnt} + 1'b1) >= {1'b0, limitVal});

  always_comb begin
    strb           = '0;
    strb.limitLoad = limitWr;
    strb.cntClr    = segWr;
    strb.cntInc    = !segWr && timerEdge && armed && !cntFull;
    strb.nmiFire   = strb.cntInc && reachLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b1;
    end else if (segWr) begin
      armed <= 1'b1;
    end else if (strb.nmiFire) begin
      armed <= 1'b0;
    end
  end

endmodule

// File: rtl/missed_tick_watchdog.sv
module missed_tick_watchdog
  import mtw_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int CNT_W     = 8,
  parameter int NMI_LEN   = 4,
  parameter int LIMIT_DEF = 5,
  parameter int IDX_W     = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               ackWr,
  input  logic [IDX_W-1:0]   ackIdx,
  input  logic               segWr,
  input  logic               limitWr,
  input  logic [CNT_W-1:0]   limitData,
  output logic [IDX_W-1:0]   statusIdx,
  output logic               irqN,
  output logic               nmiN
);

  mtwStrobe_t         strb;
  logic [NUM_SRC-1:0] pending;
  logic               timerEdge;
  logic [CNT_W-1:0]   missCnt;
  logic [CNT_W-1:0]   limitVal;

  mtw_datapath #(
    .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .NMI_LEN(NMI_LEN),
    .LIMIT_DEF(LIMIT_DEF), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ackWr(ackWr), .ackIdx(ackIdx),
    .limitData(limitData), .strb(strb), .pending(pending),
    .timerEdge(timerEdge), .missCnt(missCnt), .limitVal(limitVal), .nmiN(nmiN)
  );

  mtw_control #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .timerEdge(timerEdge), .segWr(segWr),
    .limitWr(limitWr), .missCnt(missCnt), .limitVal(limitVal), .strb(strb)
  );

  mtw_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .pending(pending), .idx(statusIdx)
  );

  assign irqN = ~|pending;

endmodule

// File: rtl/mtw_checker.sv
module mtw_checker #(
  parameter int NUM_SRC = 4,
  parameter int NMI_LEN = 4,
  parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqIn,
  input logic               segWr,
  input logic [IDX_W-1:0]   statusIdx,
  input logic               irqN,
  input logic               nmiN
);

  int   lowRun;
  logic rearmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= 0;
      rearmed <= 1'b1;
    end else begin
      lowRun <= nmiN ? 0 : lowRun + 1;
      if (segWr)            rearmed <= 1'b1;
      else if (!nmiN && $past(nmiN)) rearmed <= 1'b0;
    end
  end

  // R2: a rising request reaches the IRQ line on the next cycle
  p_edge_raises_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqIn & ~$past(reqIn))) |=> !irqN);

  // R3: status never names a source that does not exist
  p_status_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    statusIdx <= IDX_W'(NUM_SRC));

  // R11: IRQ line agrees with the encoder's view of pending work
  p_irq_status_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqN == (statusIdx == '0));

  // R7: the NMI pulse is never longer than its set width
  p_nmi_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    !nmiN |-> lowRun < NMI_LEN);

  // R7: the NMI pulse is released only after its full width
  p_nmi_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiN) |-> lowRun == NMI_LEN);

  // R8: a new NMI needs a segment write since the previous one
  p_no_refire_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiN) |-> $past(rearmed));

endmodule

bind missed_tick_watchdog mtw_checker #(
  .NUM_SRC(NUM_SRC), .NMI_LEN(NMI_LEN), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .segWr(segWr),
  .statusIdx(statusIdx), .irqN(irqN), .nmiN(nmiN)
);

// File: tb/missed_tick_watchdog_tb.sv
module missed_tick_watchdog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 4;
  localparam int CNT_W      = 8;
  localparam int NMI_LEN    = 4;
  localparam int LIMIT_DEF  = 5;
  localparam int IDX_W      = $clog2(NUM_SRC + 1);

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic               rstN;
  logic [NUM_SRC-1:0] reqIn;
  logic               ackWr;
  logic [IDX_W-1:0]   ackIdx;
  logic               segWr;
  logic               limitWr;
  logic [CNT_W-1:0]   limitData;
  logic [IDX_W-1:0]   statusIdx;
  logic               irqN;
  logic               nmiN;

  missed_tick_watchdog #(
    .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .NMI_LEN(NMI_LEN), .LIMIT_DEF(LIMIT_DEF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ackWr(ackWr), .ackIdx(ackIdx),
    .segWr(segWr), .limitWr(limitWr), .limitData(limitData),
    .statusIdx(statusIdx), .irqN(irqN), .nmiN(nmiN)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack(input int idx);
    ackWr = 1'b1;
    ackIdx = IDX_W'(idx);
    step();
    ackWr = 1'b0;
  endtask

  task automatic segWrite();
    segWr = 1'b1;
    step();
    segWr = 1'b0;
  endtask

  task automatic setLimit(input int val);
    limitWr = 1'b1;
    limitData = CNT_W'(val);
    step();
    limitWr = 1'b0;
  endtask

  // one timer edge; reports whether NMI dropped right after it
  task automatic tick(output bit fired);
    reqIn[0] = 1'b1;
    step();
    fired = !nmiN;
    reqIn[0] = 1'b0;
    ack(1);
  endtask

  task automatic settle();
    repeat (NMI_LEN + 1) step();
  endtask

  task automatic t_reset();
    bit f;
    check("R1 irqN at reset", irqN, 1);
    check("R1 nmiN at reset", nmiN, 1);
    check("R1 status at reset", statusIdx, 0);
    for (int i = 1; i < LIMIT_DEF; i++) begin
      tick(f);
      check("R1 R6 no NMI below default limit", f, 0);
    end
    tick(f);
    check("R1 R6 NMI on default limit tick", f, 1);
    settle();
  endtask

  task automatic t_edge();
    reqIn[2] = 1'b1;
    step();
    check("R2 R11 irqN after edge", irqN, 0);
    check("R2 status after edge", statusIdx, 3);
    ack(3);
    check("R2 R11 held level does not retrigger", irqN, 1);
    repeat (3) step();
    check("R2 held level still idle", statusIdx, 0);
    reqIn[2] = 1'b0;
    step();
    reqIn[2] = 1'b1;
    step();
    check("R2 new edge after release", statusIdx, 3);
    reqIn[2] = 1'b0;
    ack(3);
  endtask

  task automatic t_prio();
    reqIn[3] = 1'b1;
    step();
    check("R3 single low source", statusIdx, 4);
    reqIn[1] = 1'b1;
    step();
    check("R3 higher source wins", statusIdx, 2);
    reqIn[0] = 1'b1;
    step();
    check("R3 timer is top", statusIdx, 1);
    reqIn = '0;
    ack(1);
    check("R4 next source revealed", statusIdx, 2);
    ack(2);
    check("R4 lowest source kept", statusIdx, 4);
    ack(4);
    check("R3 none pending", statusIdx, 0);
    check("R11 irq released", irqN, 1);
  endtask

  task automatic t_ack_rules();
    reqIn[2] = 1'b1;
    step();
    reqIn[2] = 1'b0;
    reqIn[3] = 1'b1;
    step();
    reqIn[3] = 1'b0;
    ack(4);
    check("R5 ack clears only its source", statusIdx, 3);
    ackWr = 1'b1;
    ackIdx = IDX_W'(3);
    reqIn[2] = 1'b1;
    step();
    ackWr = 1'b0;
    reqIn[2] = 1'b0;
    check("R5 same-cycle edge beats ack", statusIdx, 3);
    ack(3);
    check("R5 ack clears source", statusIdx, 0);
  endtask

  task automatic t_nmi_pulse();
    bit f;
    setLimit(3);
    segWrite();
    for (int i = 0; i < 2; i++) begin
      tick(f);
      check("R6 no NMI before limit", f, 0);
    end
    reqIn[0] = 1'b1;
    step();
    check("R7 NMI low after limit tick", nmiN, 0);
    reqIn[0] = 1'b0;
    for (int i = 1; i < NMI_LEN; i++) begin
      step();
      check("R7 NMI held low", nmiN, 0);
    end
    step();
    check("R7 NMI released after width", nmiN, 1);
    ack(1);
  endtask

  task automatic t_saturate();
    bit f;
    for (int i = 0; i < 6; i++) begin
      tick(f);
      check("R8 no second NMI", f, 0);
    end
    settle();
    check("R8 NMI idle", nmiN, 1);
  endtask

  task automatic t_segclr();
    bit f;
    segWrite();
    tick(f);
    tick(f);
    segWrite();
    tick(f);
    check("R9 count cleared by segment write", f, 0);
    tick(f);
    check("R9 count cleared by segment write", f, 0);
    segWr = 1'b1;
    reqIn[0] = 1'b1;
    step();
    check("R9 same-cycle tick no NMI", nmiN, 1);
    segWr = 1'b0;
    reqIn[0] = 1'b0;
    ack(1);
    tick(f);
    check("R9 tick 1 after clear", f, 0);
    tick(f);
    check("R9 same-cycle tick not counted", f, 0);
    tick(f);
    check("R9 NMI on third tick after clear", f, 1);
    settle();
  endtask

  task automatic t_limit();
    bit f;
    setLimit(1);
    segWrite();
    tick(f);
    check("R10 limit 1 fires on first tick", f, 1);
    settle();
    setLimit(0);
    segWrite();
    for (int i = 0; i < 12; i++) begin
      tick(f);
      check("R10 limit 0 disables watchdog", f, 0);
    end
    setLimit(LIMIT_DEF);
    segWrite();
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0;
    reqIn = '0;
    ackWr = 1'b0;
    ackIdx = '0;
    segWr = 1'b0;
    limitWr = 1'b0;
    limitData = '0;
    @(negedge clk);
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_edge();
    t_prio();
    t_ack_rules();
    t_nmi_pulse();
    t_saturate();
    t_segclr();
    t_limit();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

endmodule